// File: doc/BRIEF.md
# Interrupt Status with Halt and Reset Handshakes

This block gathers single-cycle event pulses from two bus masters, each with two command queues, and from its own halt and reset sequencers, into one 32-bit status word. Software reads the word, clears bits by writing ones, and releases the single interrupt line with a separate global-clear strobe. An enable mask decides which status bits may raise the interrupt. Each master also has a fixed error group, the set of its fault and NACK bits, and the block reports whether any bit of that group is pending.

Two handshakes sit beside the status word. A halt request for a master stops both of its queues, waits a fixed drain time and then posts that master's halt acknowledge. A reset command carries a mask that names the masters to flush. After a fixed flush time the block posts the reset-done acknowledge and releases the halted masters the command named. Each sequencer is an enumerated state machine. Halt: RUN to DRAIN on a request, DRAIN to ACK when the drain count ends, ACK to HELD after one cycle, HELD to RUN on a reset release. Reset: IDLE to FLUSH on a legal command, FLUSH to DONE when the flush count ends, DONE to IDLE after one cycle. The interrupt line has its own machine: QUIET to RAISED when a masked bit is pending, RAISED to QUIET on a global clear.

Top module: `evt_irq_ctrl`

## Requirements
- R1: An event pulse sets its status bit at the next clock edge. The bit positions are: read done at 0 (master 0) and 12 (master 1); queue report at 4+4q+12m; fault k (k=0..7) at 1,2,5,6,7,9,10,11 plus 12m; NACK at 27+2m+q; reset-done at 24; halt acknowledge at 25+m. Event input index is m for read done and m*2+q for report and NACK, and m*8+k for faults.
- R2: A clear write removes exactly the status bits written as one and leaves all others unchanged. Bits with no meaning stay 0.
- R3: An event that arrives in the same cycle as a clear of its own bit wins, and the bit stays set.
- R4: The interrupt rises one edge after the status ANDed with the mask becomes nonzero. A pending bit that is masked off never raises it. A mask write takes effect at the edge that samples it.
- R5: Once raised, the interrupt stays high through status clears until a global clear. The global clear drops it at that edge, and it rises again on the next edge if masked status is still pending.
- R6: A halt request bit m, sampled at edge k while master m runs, sets halted_o[m] at edge k and sets status bit 25+m at edge k+DRAIN_CYC+1.
- R7: A halt request to a master that is already halting or halted is ignored and posts no second acknowledge.
- R8: A reset command is legal when bit 0 is set and no bit outside 0x0f73f3f7 is set; otherwise it is ignored. Bits [9:4] all set target master 0 and bits [17:12] all set target master 1. A legal command sampled at edge k sets status bit 24 at edge k+RST_CYC+1 and, at the same edge, clears halted_o for each targeted halted master. Untargeted masters stay halted.
- R9: A reset command that arrives while a reset is in progress is ignored. Only one reset-done is posted.
- R10: err_o[m] is high while any bit of master m's error group is set (0x18000ee6 for master 0, 0x60ee6000 for master 1). nack_o[m] is high while either of master m's NACK bits is set.
- R11: After reset the status, mask, interrupt and halted flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_rd_done_i | input | 2 | Read-done pulse per master |
| evt_report_i | input | 4 | Queue report pulse, index m*2+q |
| evt_nack_i | input | 4 | NACK pulse, index m*2+q |
| evt_fault_i | input | 16 | Other fault pulses, index m*8+k |
| clr_we_i | input | 1 | Clear strobe |
| clr_data_i | input | 32 | Bits to clear |
| gclr_i | input | 1 | Global clear strobe releasing the interrupt |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 32 | New interrupt enable mask |
| halt_we_i | input | 1 | Halt request strobe |
| halt_data_i | input | 2 | Bit m requests a halt of master m |
| rst_we_i | input | 1 | Reset command strobe |
| rst_data_i | input | 32 | Reset command mask |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt line |
| halted_o | output | 2 | Master queues stopped |
| err_o | output | 2 | Error group pending per master |
| nack_o | output | 2 | NACK pending per master |

## Verification
The status word is driven with mixed events from both masters in one cycle. This separates the position of every bit class and the index order of the event buses. Clears that name a mix of set, unset and unused bits separate exact one-to-clear from wider clearing. Clears collide with events on the same bit and on different bits, which shows the event priority. The interrupt is tried with masked-off pending bits, with a mask write, and with a global clear while bits are still pending. These cases separate the gating, the latency and the re-raise. The handshakes are tried with repeated halts, illegal and partial reset masks, and overlapping reset commands. These show the exact acknowledge cycle, which masters a command releases, and that a busy sequencer ignores new requests.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int NUM_M     = 2;
    localparam int NUM_Q     = 2;
    localparam int FAULT_W   = 8;
    localparam int REG_W     = 32;
    localparam int NQ_TOTAL  = NUM_M * NUM_Q;
    localparam int RST_ACK_POS = 24;
    localparam logic [REG_W-1:0] RST_LEGAL = 32'h0f73f3f7;

    typedef enum logic [1:0] {H_RUN, H_DRAIN, H_ACK, H_HELD} halt_st_e;
    typedef enum logic [1:0] {R_IDLE, R_FLUSH, R_DONE} rst_st_e;
    typedef enum logic       {I_QUIET, I_RAISED} irq_st_e;

    function automatic int rd_pos(int m);
        return 12 * m;
    endfunction

    function automatic int report_pos(int m, int q);
        return 4 + 4 * q + 12 * m;
    endfunction

    function automatic int nack_pos(int m, int q);
        return 27 + 2 * m + q;
    endfunction

    function automatic int halt_ack_pos(int m);
        return 25 + m;
    endfunction

    function automatic int fault_pos(int m, int k);
        int base;
        case (k)
            0: base = 1;
            1: base = 2;
            2: base = 5;
            3: base = 6;
            4: base = 7;
            5: base = 9;
            6: base = 10;
            default: base = 11;
        endcase
        return base + 12 * m;
    endfunction

    function automatic logic [REG_W-1:0] rst_sel(int m);
        return REG_W'(32'h3f) << (4 + 8 * m);
    endfunction

    function automatic logic [REG_W-1:0] err_group(int m);
        logic [REG_W-1:0] g;
        g = '0;
        for (int k = 0; k < FAULT_W; k++) g[fault_pos(m, k)] = 1'b1;
        for (int q = 0; q < NUM_Q; q++) g[nack_pos(m, q)] = 1'b1;
        return g;
    endfunction

    function automatic logic [REG_W-1:0] nack_group(int m);
        logic [REG_W-1:0] g;
        g = '0;
        for (int q = 0; q < NUM_Q; q++) g[nack_pos(m, q)] = 1'b1;
        return g;
    endfunction
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg
    import evt_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             clr_we_i,
    input  logic [REG_W-1:0] clr_i,
    input  logic             gclr_i,
    input  logic             mask_we_i,
    input  logic [REG_W-1:0] mask_i,
    output logic [REG_W-1:0] status_o,
    output logic             irq_o
);
    logic [REG_W-1:0] status_q, status_n, mask_q, clr_eff;
    irq_st_e          irq_q, irq_n;
    logic             pending;

    always_comb begin
        clr_eff  = clr_we_i ? clr_i : '0;
        status_n = (status_q & ~clr_eff) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_n;
            if (mask_we_i) mask_q <= mask_i;
        end
    end

    assign pending = |(status_q & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= I_QUIET;
        else        irq_q <= irq_n;
    end

    always_comb begin
        irq_n = irq_q;
        unique case (irq_q)
            I_QUIET:  if (pending) irq_n = I_RAISED;
            I_RAISED: if (gclr_i)  irq_n = I_QUIET;
        endcase
    end

    always_comb begin
        status_o = status_q;
        irq_o    = (irq_q == I_RAISED);
    end

    assert_evt_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    assert_clr_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((status_q & $past(clr_i & ~set_i)) == '0));

    assert_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(status_q & mask_q)));

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !gclr_i) |=> irq_o);
endmodule

// File: rtl/evt_halt_fsm.sv
module evt_halt_fsm
    import evt_irq_pkg::*;
#(
    parameter int DRAIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic release_i,
    output logic halted_o,
    output logic ack_o
);
    localparam int CW = $clog2(DRAIN_CYC + 2);
    localparam logic [CW-1:0] LAST = CW'(DRAIN_CYC - 1);

    halt_st_e        st_q, st_n;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= H_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= (st_q == H_DRAIN) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            H_RUN:   if (req_i)         st_n = H_DRAIN;
            H_DRAIN: if (cnt_q == LAST) st_n = H_ACK;
            H_ACK:                      st_n = H_HELD;
            H_HELD:  if (release_i)     st_n = H_RUN;
        endcase
    end

    always_comb begin
        halted_o = (st_q != H_RUN);
        ack_o    = (st_q == H_ACK);
    end

    // checker window: cycles since the request was taken
    logic [CW-1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       since_q <= '1;
        else if (st_q == H_RUN && req_i)  since_q <= '0;
        else if (since_q != '1)           since_q <= since_q + 1'b1;
    end

    assert_ack_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (since_q == CW'(DRAIN_CYC)));

    assert_single_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    assert_req_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> halted_o);
endmodule

// File: rtl/evt_reset_fsm.sv
module evt_reset_fsm
    import evt_irq_pkg::*;
#(
    parameter int RST_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we_i,
    input  logic [REG_W-1:0] cmd_i,
    output logic             done_o,
    output logic [NUM_M-1:0] rel_o
);
    localparam int CW = $clog2(RST_CYC + 2);
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    rst_st_e          st_q, st_n;
    logic [CW-1:0]    cnt_q;
    logic [NUM_M-1:0] tgt_q, tgt_n;
    logic             legal, accept;

    always_comb begin
        legal  = cmd_i[0] && ((cmd_i & ~RST_LEGAL) == '0);
        accept = cmd_we_i && legal && (st_q == R_IDLE);
        for (int m = 0; m < NUM_M; m++)
            tgt_n[m] = ((cmd_i & rst_sel(m)) == rst_sel(m));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= R_IDLE;
            cnt_q <= '0;
            tgt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= (st_q == R_FLUSH) ? cnt_q + 1'b1 : '0;
            if (accept) tgt_q <= tgt_n;
        end
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            R_IDLE:  if (accept)         st_n = R_FLUSH;
            R_FLUSH: if (cnt_q == LAST)  st_n = R_DONE;
            R_DONE:                      st_n = R_IDLE;
            default:                     st_n = R_IDLE;
        endcase
    end

    always_comb begin
        done_o = (st_q == R_DONE);
        rel_o  = (st_q == R_DONE) ? tgt_q : '0;
    end

    logic [CW-1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_q <= '1;
        else if (accept)          since_q <= '0;
        else if (since_q != '1)   since_q <= since_q + 1'b1;
    end

    assert_done_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_q == CW'(RST_CYC)));

    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != R_IDLE && cmd_we_i) |=> $stable(tgt_q));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int DRAIN_CYC = 4,
    parameter int RST_CYC   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_M-1:0]         evt_rd_done_i,
    input  logic [NQ_TOTAL-1:0]      evt_report_i,
    input  logic [NQ_TOTAL-1:0]      evt_nack_i,
    input  logic [NUM_M*FAULT_W-1:0] evt_fault_i,
    input  logic                     clr_we_i,
    input  logic [REG_W-1:0]         clr_data_i,
    input  logic                     gclr_i,
    input  logic                     mask_we_i,
    input  logic [REG_W-1:0]         mask_data_i,
    input  logic                     halt_we_i,
    input  logic [NUM_M-1:0]         halt_data_i,
    input  logic                     rst_we_i,
    input  logic [REG_W-1:0]         rst_data_i,
    output logic [REG_W-1:0]         status_o,
    output logic                     irq_o,
    output logic [NUM_M-1:0]         halted_o,
    output logic [NUM_M-1:0]         err_o,
    output logic [NUM_M-1:0]         nack_o
);
    logic [REG_W-1:0] set_v;
    logic [NUM_M-1:0] halt_ack, rel;
    logic             rst_done;

    always_comb begin
        set_v = '0;
        set_v[RST_ACK_POS] = rst_done;
        for (int m = 0; m < NUM_M; m++) begin
            set_v[rd_pos(m)]       = evt_rd_done_i[m];
            set_v[halt_ack_pos(m)] = halt_ack[m];
            for (int q = 0; q < NUM_Q; q++) begin
                set_v[report_pos(m, q)] = evt_report_i[m*NUM_Q + q];
                set_v[nack_pos(m, q)]   = evt_nack_i[m*NUM_Q + q];
            end
            for (int k = 0; k < FAULT_W; k++)
                set_v[fault_pos(m, k)] = evt_fault_i[m*FAULT_W + k];
        end
    end

    evt_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_v),
        .clr_we_i (clr_we_i),
        .clr_i    (clr_data_i),
        .gclr_i   (gclr_i),
        .mask_we_i(mask_we_i),
        .mask_i   (mask_data_i),
        .status_o (status_o),
        .irq_o    (irq_o)
    );

    evt_reset_fsm #(.RST_CYC(RST_CYC)) u_reset (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_we_i(rst_we_i),
        .cmd_i   (rst_data_i),
        .done_o  (rst_done),
        .rel_o   (rel)
    );

    for (genvar m = 0; m < NUM_M; m++) begin : g_master
        evt_halt_fsm #(.DRAIN_CYC(DRAIN_CYC)) u_halt (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (halt_we_i && halt_data_i[m]),
            .release_i(rel[m]),
            .halted_o (halted_o[m]),
            .ack_o    (halt_ack[m])
        );

        always_comb begin
            err_o[m]  = |(status_o & err_group(m));
            nack_o[m] = |(status_o & nack_group(m));
        end

        assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (halted_o[m] && !rel[m] && !halt_ack[m] && !(halt_we_i && halt_data_i[m]))
            |=> halted_o[m]);
    end
endmodule

// File: tb/tb_evt_irq_ctrl.sv
`timescale 1ns/1ps
module tb_evt_irq_ctrl;
    localparam int DRAIN = 4;
    localparam int RSTC  = 6;

    logic        clk = 0, rst_n = 0;
    logic [1:0]  rd = 0;
    logic [3:0]  rep = 0, nk = 0;
    logic [15:0] flt = 0;
    logic        clr_we = 0, gclr = 0, mask_we = 0, halt_we = 0, rst_we = 0;
    logic [31:0] clr_d = 0, mask_d = 0, rst_d = 0;
    logic [1:0]  halt_d = 0;
    logic [31:0] status;
    logic        irq;
    logic [1:0]  halted, err, nack;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    evt_irq_ctrl #(.DRAIN_CYC(DRAIN), .RST_CYC(RSTC)) dut (
        .clk(clk), .rst_n(rst_n),
        .evt_rd_done_i(rd), .evt_report_i(rep), .evt_nack_i(nk), .evt_fault_i(flt),
        .clr_we_i(clr_we), .clr_data_i(clr_d), .gclr_i(gclr),
        .mask_we_i(mask_we), .mask_data_i(mask_d),
        .halt_we_i(halt_we), .halt_data_i(halt_d),
        .rst_we_i(rst_we), .rst_data_i(rst_d),
        .status_o(status), .irq_o(irq), .halted_o(halted), .err_o(err), .nack_o(nack)
    );

    // scoreboard queues
    string       q_tag[$];
    logic [31:0] q_st[$];
    logic        q_irq[$];
    logic [1:0]  q_h[$];

    task automatic expect_now(string tag, logic [31:0] st, logic ir, logic [1:0] h);
        q_tag.push_back(tag); q_st.push_back(st); q_irq.push_back(ir); q_h.push_back(h);
    endtask

    initial forever begin
        @(negedge clk);
        #1;
        while (q_tag.size() > 0) begin
            string t; logic [31:0] es; logic ei; logic [1:0] eh, ee, en;
            t = q_tag.pop_front(); es = q_st.pop_front();
            ei = q_irq.pop_front(); eh = q_h.pop_front();
            ee = {|(es & 32'h60ee6000), |(es & 32'h18000ee6)};
            en = {|(es & 32'h60000000), |(es & 32'h18000000)};
            total++;
            if (status !== es || irq !== ei || halted !== eh || err !== ee || nack !== en) begin
                bad++;
                $display("FAIL %s status=%h exp=%h irq=%b exp=%b halted=%b exp=%b err=%b exp=%b nack=%b exp=%b",
                         t, status, es, irq, ei, halted, eh, err, ee, nack, en);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        rd = 0; rep = 0; nk = 0; flt = 0;
        clr_we = 0; gclr = 0; mask_we = 0; halt_we = 0; rst_we = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 50000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        expect_now("R11 reset state", 32'h0, 0, 2'b00);
        idle(1);

        // R1: mixed events from both masters
        rd = 2'b01; rep = 4'b0110; flt = 16'h0008; nk = 4'b1000;
        tick();
        expect_now("R1 positions / R4 masked-off no irq", 32'h40010141, 0, 2'b00);

        // R2: clear set, unset and unused bits
        clr_we = 1; clr_d = 32'h00010109; tick();
        expect_now("R2 exact clear", 32'h40000040, 0, 2'b00);

        // R4: mask latency
        mask_we = 1; mask_d = 32'h40; tick();
        expect_now("R4 mask write edge", 32'h40000040, 0, 2'b00);
        idle(1);
        expect_now("R4 irq raised", 32'h40000040, 1, 2'b00);

        // R5: latched through clear
        clr_we = 1; clr_d = 32'hffffffff; tick();
        expect_now("R5 irq held after clear", 32'h0, 1, 2'b00);
        idle(2);
        expect_now("R5 irq still held", 32'h0, 1, 2'b00);
        gclr = 1; tick();
        expect_now("R5 global clear drops irq", 32'h0, 0, 2'b00);
        idle(1);
        expect_now("R5 stays low, nothing pending", 32'h0, 0, 2'b00);

        mask_we = 1; mask_d = 32'h1040; tick();
        rd = 2'b10; tick();
        expect_now("R1 read done m1 / R4 one edge later", 32'h1000, 0, 2'b00);
        idle(1);
        expect_now("R4 irq after pending", 32'h1000, 1, 2'b00);
        gclr = 1; tick();
        expect_now("R5 gclr with pending", 32'h1000, 0, 2'b00);
        idle(1);
        expect_now("R5 re-raise", 32'h1000, 1, 2'b00);

        // R3: event versus clear
        rd = 2'b10; clr_we = 1; clr_d = 32'h1000; tick();
        expect_now("R3 event wins", 32'h1000, 1, 2'b00);
        rep = 4'b0001; clr_we = 1; clr_d = 32'h1010; tick();
        expect_now("R3 mixed clear and event", 32'h10, 1, 2'b00);

        mask_we = 1; mask_d = 0; tick();
        clr_we = 1; clr_d = 32'hffffffff; tick();
        gclr = 1; tick();
        expect_now("R5 quiet after clear and gclr", 32'h0, 0, 2'b00);

        // R6: halt master 0
        halt_we = 1; halt_d = 2'b01; tick();
        expect_now("R6 halted at once", 32'h0, 0, 2'b01);
        idle(DRAIN);
        expect_now("R6 no ack before drain ends", 32'h0, 0, 2'b01);
        idle(1);
        expect_now("R6 halt ack m0", 32'h02000000, 0, 2'b01);

        // R7: repeated halt ignored
        clr_we = 1; clr_d = 32'h02000000; tick();
        halt_we = 1; halt_d = 2'b01; tick();
        idle(DRAIN + 2);
        expect_now("R7 no second ack", 32'h0, 0, 2'b01);

        // R8: illegal commands
        rst_we = 1; rst_d = 32'h3f0; tick();
        idle(RSTC + 2);
        expect_now("R8 bit0 missing ignored", 32'h0, 0, 2'b01);
        rst_we = 1; rst_d = 32'h100003f1; tick();
        idle(RSTC + 2);
        expect_now("R8 stray bit ignored", 32'h0, 0, 2'b01);

        halt_we = 1; halt_d = 2'b10; tick();
        idle(DRAIN + 1);
        expect_now("R6 halt ack m1", 32'h04000000, 0, 2'b11);
        clr_we = 1; clr_d = 32'h04000000; tick();

        // R8: reset master 0 only
        rst_we = 1; rst_d = 32'h3f1; tick();
        idle(RSTC);
        expect_now("R8 not done yet", 32'h0, 0, 2'b11);
        idle(1);
        expect_now("R8 done, m0 released, m1 held", 32'h01000000, 0, 2'b10);

        // R9: overlapping commands
        clr_we = 1; clr_d = 32'h01000000; tick();
        rst_we = 1; rst_d = 32'h0f73f3f7; tick();
        idle(1);
        rst_we = 1; rst_d = 32'h3f001; tick();
        idle(RSTC - 2);
        expect_now("R9 first reset still flushing", 32'h0, 0, 2'b10);
        idle(1);
        expect_now("R8 full reset releases m1", 32'h01000000, 0, 2'b00);
        clr_we = 1; clr_d = 32'h01000000; tick();
        idle(RSTC + 2);
        expect_now("R9 no second done", 32'h0, 0, 2'b00);

        // R10: error group summaries
        flt = 16'h0100; tick();
        expect_now("R10 fault m1 bit13", 32'h2000, 0, 2'b00);
        nk = 4'b0001; tick();
        expect_now("R10 nack m0q0 bit27", 32'h08002000, 0, 2'b00);

        idle(2);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule